// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the pixel-rate strobe and the line sync, frame sync and data-enable signals for a parallel TFT panel. It also produces the live pixel and line positions that a downstream fetch unit uses to step through the frame. The block is driven by a set of timing fields and a power-enable level, and it has no interface for software of its own.

Each line is laid out as active pixels, then front porch, then sync pulse, then back porch. Each frame follows the same order, counted in lines. The horizontal porch and sync fields, the vertical sync field and both active sizes are written as the count minus one. The vertical porches are written as the plain count, so either vertical porch may be zero.

The pixel strobe fires once every 2×(divider+1) system clocks, or on every clock when bypass is set. The timing fields are sampled into a shadow copy when a frame starts, so a change made mid-frame never tears a frame. When power-enable drops, the block finishes the frame in progress and only then goes idle. `busy` stays high until the block is idle.

Top module: `lcd_sync_gen`

## Requirements
- R1: With `div_bypass` low, `pix_ce` is high for exactly one system clock in every 2×(`div_val`+1) clocks while running. The first pulse comes on the 2×(`div_val`+1)-th running clock.
- R2: With `div_bypass` high, `pix_ce` is high on every clock while running.
- R3: On each `pix_ce`, `pix_x` counts from 0 to (h_act_m1+1)+(h_fp_m1+1)+(h_sw_m1+1)+(h_bp_m1+1)−1 and then returns to 0.
- R4: `line_y` advances when `pix_x` wraps, and counts from 0 to (v_act_m1+1)+v_fp+(v_sw_m1+1)+v_bp−1 before returning to 0. The vertical porches are taken as direct counts.
- R5: `hsync` is asserted while `pix_x` is in [h_act_m1+h_fp_m1+2, h_act_m1+h_fp_m1+h_sw_m1+3).
- R6: `vsync` is asserted while `line_y` is in [v_act_m1+1+v_fp, v_act_m1+v_fp+v_sw_m1+2).
- R7: With `hs_inv` set, `hsync` is active low; with `vs_inv` set, `vsync` is active low. While idle, each sync rests at its inactive level.
- R8: `de` is high only while running with `pix_x` ≤ h_act_m1 and `line_y` ≤ v_act_m1.
- R9: Timing fields that change in the middle of a frame take effect only from the first pixel of the next frame.
- R10: While `pwr_en` is low, `busy` stays high until the frame in progress has ended. The block then goes idle with `pix_ce` and `de` low and both positions at 0.
- R11: After reset, the block is idle with all outputs at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Starts generation; when low, stops generation at the end of the frame |
| div_val | input | 8 | Pixel strobe divider; period is 2×(div_val+1) clocks |
| div_bypass | input | 1 | Pixel strobe on every clock |
| h_act_m1 | input | 10 | Active pixels per line, minus one |
| h_fp_m1 | input | 10 | Horizontal front porch, minus one |
| h_sw_m1 | input | 10 | Line sync width, minus one |
| h_bp_m1 | input | 10 | Horizontal back porch, minus one |
| v_act_m1 | input | 10 | Active lines, minus one |
| v_fp | input | 10 | Vertical front porch in lines |
| v_sw_m1 | input | 10 | Frame sync width in lines, minus one |
| v_bp | input | 10 | Vertical back porch in lines |
| hs_inv | input | 1 | Line sync active low |
| vs_inv | input | 1 | Frame sync active low |
| pix_ce | output | 1 | Pixel-rate strobe |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data enable |
| pix_x | output | 12 | Pixel position within the line |
| line_y | output | 12 | Line position within the frame |
| busy | output | 1 | Generation in progress |

## Verification
Every output is a combinational function of registered state, so the effect of a position step or a shadow load shows in the cycle that follows the clock edge that caused it. The first running cycle comes one edge after `pwr_en` is seen high in idle. A reference model in the bench advances its own positions, divider tick and shadow copy on each rising edge from the same inputs. The bench compares every output against that model at each falling edge, which is half a cycle after the edge that made the value. Mid-frame field changes and power-down checks therefore land on the exact frame-end edge with no extra slack.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

    localparam int LCD_HFW = 10;
    localparam int LCD_VFW = 10;
    localparam int LCD_DFW = 8;

    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_e;

    typedef struct packed {
        logic [LCD_DFW-1:0] div;
        logic               bypass;
        logic [LCD_HFW-1:0] h_act_m1;
        logic [LCD_HFW-1:0] h_fp_m1;
        logic [LCD_HFW-1:0] h_sw_m1;
        logic [LCD_HFW-1:0] h_bp_m1;
        logic [LCD_VFW-1:0] v_act_m1;
        logic [LCD_VFW-1:0] v_fp;
        logic [LCD_VFW-1:0] v_sw_m1;
        logic [LCD_VFW-1:0] v_bp;
        logic               hs_inv;
        logic               vs_inv;
    } timing_cfg_t;

endpackage

// File: rtl/lcd_pclk_div.sv
module lcd_pclk_div #(
    parameter int DFW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [DFW-1:0] div,
    input  logic           bypass,
    output logic           ce
);
    localparam int CNTW = DFW + 1;

    logic [CNTW-1:0] tick_q;
    logic [CNTW-1:0] last_tick;

    // period of 2*(div+1) clocks: last tick index is 2*div+1
    assign last_tick = {div, 1'b1};
    assign ce = run && (bypass || (tick_q == last_tick));

    always_ff @(posedge clk) begin
        if (rst || !run || ce) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + CNTW'(1);
        end
    end
endmodule

// File: rtl/lcd_axis_cnt.sv
module lcd_axis_cnt #(
    parameter int FW       = 10,
    parameter bit PORCH_M1 = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    input  logic [FW-1:0] act_m1,
    input  logic [FW-1:0] fp,
    input  logic [FW-1:0] sw_m1,
    input  logic [FW-1:0] bp,
    output logic [FW+1:0] pos,
    output logic          wrap,
    output logic          in_act,
    output logic          in_sync
);
    localparam int CW = FW + 2;

    logic [CW-1:0] fp_len;
    logic [CW-1:0] bp_len;
    logic [CW-1:0] sync_start;
    logic [CW-1:0] sync_end;
    logic [CW-1:0] last_pos;
    logic [CW-1:0] pos_q;

    generate
        if (PORCH_M1) begin : g_porch_m1
            assign fp_len = CW'(fp) + CW'(1);
            assign bp_len = CW'(bp) + CW'(1);
        end else begin : g_porch_direct
            assign fp_len = CW'(fp);
            assign bp_len = CW'(bp);
        end
    endgenerate

    assign sync_start = CW'(act_m1) + CW'(1) + fp_len;
    assign sync_end   = sync_start + CW'(sw_m1) + CW'(1);
    assign last_pos   = sync_end + bp_len - CW'(1);

    assign wrap    = step && (pos_q == last_pos);
    assign in_act  = pos_q <= CW'(act_m1);
    assign in_sync = (pos_q >= sync_start) && (pos_q < sync_end);
    assign pos     = pos_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pos_q <= '0;
        end else if (step) begin
            pos_q <= wrap ? '0 : pos_q + CW'(1);
        end
    end
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
    import lcd_sync_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_en,
    input  logic [LCD_DFW-1:0] div_val,
    input  logic               div_bypass,
    input  logic [LCD_HFW-1:0] h_act_m1,
    input  logic [LCD_HFW-1:0] h_fp_m1,
    input  logic [LCD_HFW-1:0] h_sw_m1,
    input  logic [LCD_HFW-1:0] h_bp_m1,
    input  logic [LCD_VFW-1:0] v_act_m1,
    input  logic [LCD_VFW-1:0] v_fp,
    input  logic [LCD_VFW-1:0] v_sw_m1,
    input  logic [LCD_VFW-1:0] v_bp,
    input  logic               hs_inv,
    input  logic               vs_inv,
    output logic               pix_ce,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic [LCD_HFW+1:0] pix_x,
    output logic [LCD_VFW+1:0] line_y,
    output logic               busy
);
    gen_state_e  state_q;
    timing_cfg_t live_cfg;
    timing_cfg_t shd;
    logic        running;
    logic        h_wrap, h_act, h_sync;
    logic        v_wrap, v_act, v_sync;
    logic        frame_end;
    logic        load_shd;

    always_comb begin
        live_cfg.div      = div_val;
        live_cfg.bypass   = div_bypass;
        live_cfg.h_act_m1 = h_act_m1;
        live_cfg.h_fp_m1  = h_fp_m1;
        live_cfg.h_sw_m1  = h_sw_m1;
        live_cfg.h_bp_m1  = h_bp_m1;
        live_cfg.v_act_m1 = v_act_m1;
        live_cfg.v_fp     = v_fp;
        live_cfg.v_sw_m1  = v_sw_m1;
        live_cfg.v_bp     = v_bp;
        live_cfg.hs_inv   = hs_inv;
        live_cfg.vs_inv   = vs_inv;
    end

    assign running   = (state_q == GEN_RUN);
    assign frame_end = v_wrap;
    assign load_shd  = pwr_en && (!running || frame_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GEN_IDLE;
            shd     <= '0;
        end else begin
            if (load_shd) begin
                shd <= live_cfg;
            end
            case (state_q)
                GEN_IDLE: if (pwr_en) state_q <= GEN_RUN;
                GEN_RUN:  if (frame_end && !pwr_en) state_q <= GEN_IDLE;
                default:  state_q <= GEN_IDLE;
            endcase
        end
    end

    lcd_pclk_div #(.DFW(LCD_DFW)) u_div (
        .clk    (clk),
        .rst    (rst),
        .run    (running),
        .div    (shd.div),
        .bypass (shd.bypass),
        .ce     (pix_ce)
    );

    lcd_axis_cnt #(.FW(LCD_HFW), .PORCH_M1(1'b1)) u_hcnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (!running),
        .step    (pix_ce),
        .act_m1  (shd.h_act_m1),
        .fp      (shd.h_fp_m1),
        .sw_m1   (shd.h_sw_m1),
        .bp      (shd.h_bp_m1),
        .pos     (pix_x),
        .wrap    (h_wrap),
        .in_act  (h_act),
        .in_sync (h_sync)
    );

    lcd_axis_cnt #(.FW(LCD_VFW), .PORCH_M1(1'b0)) u_vcnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (!running),
        .step    (h_wrap),
        .act_m1  (shd.v_act_m1),
        .fp      (shd.v_fp),
        .sw_m1   (shd.v_sw_m1),
        .bp      (shd.v_bp),
        .pos     (line_y),
        .wrap    (v_wrap),
        .in_act  (v_act),
        .in_sync (v_sync)
    );

    assign busy  = running;
    assign de    = running && h_act && v_act;
    assign hsync = (running && h_sync) ^ shd.hs_inv;
    assign vsync = (running && v_sync) ^ shd.vs_inv;
endmodule

// File: rtl/lcd_sync_chk.sv
module lcd_sync_chk
    import lcd_sync_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               pix_ce,
    input logic               de,
    input logic               byp,
    input logic [LCD_HFW+1:0] pix_x,
    input logic [LCD_VFW+1:0] line_y
);
    AST_BYPASS_EVERY_CLK: assert property (@(posedge clk) disable iff (rst)
        (busy && byp) |-> pix_ce); // R2

    AST_X_HOLDS_WITHOUT_CE: assert property (@(posedge clk) disable iff (rst)
        (busy && !pix_ce) |=> $stable(pix_x)); // R3

    AST_Y_HOLDS_WITHOUT_CE: assert property (@(posedge clk) disable iff (rst)
        (busy && !pix_ce) |=> $stable(line_y)); // R4

    AST_DE_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
        de |-> busy); // R8

    AST_IDLE_NO_CE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!pix_ce && pix_x == '0 && line_y == '0)); // R10

    AST_STOP_AT_FRAME_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(pix_ce)); // R10
endmodule

bind lcd_sync_gen lcd_sync_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy   (busy),
    .pix_ce (pix_ce),
    .de     (de),
    .byp    (shd.bypass),
    .pix_x  (pix_x),
    .line_y (line_y)
);

// File: tb/lcd_sync_gen_test.sv
module lcd_sync_gen_test;
    import lcd_sync_pkg::*;

    localparam int HW = LCD_HFW;
    localparam int VW = LCD_VFW;
    localparam int DW = LCD_DFW;
    localparam int NCFG = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_en = 1'b0;
    int   live [NCFG];
    int   sh   [NCFG];

    logic          pix_ce, hsync, vsync, de, busy;
    logic [HW+1:0] pix_x;
    logic [VW+1:0] line_y;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit rst_phase = 1'b1;

    bit m_run;
    int m_tick, m_x, m_y;

    always #10 clk = ~clk;

    lcd_sync_gen uut (
        .clk(clk), .rst(rst), .pwr_en(pwr_en),
        .div_val(DW'(live[0])), .div_bypass(live[1][0]),
        .h_act_m1(HW'(live[2])), .h_fp_m1(HW'(live[3])),
        .h_sw_m1(HW'(live[4])), .h_bp_m1(HW'(live[5])),
        .v_act_m1(VW'(live[6])), .v_fp(VW'(live[7])),
        .v_sw_m1(VW'(live[8])), .v_bp(VW'(live[9])),
        .hs_inv(live[10][0]), .vs_inv(live[11][0]),
        .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_x(pix_x), .line_y(line_y), .busy(busy)
    );

    function automatic int h_total();
        return sh[2] + sh[3] + sh[4] + sh[5] + 4;
    endfunction
    function automatic int v_total();
        return sh[6] + 1 + sh[7] + sh[8] + 1 + sh[9];
    endfunction
    function automatic int hs_first();
        return sh[2] + sh[3] + 2;
    endfunction
    function automatic int vs_first();
        return sh[6] + 1 + sh[7];
    endfunction
    function automatic bit exp_ce();
        return m_run && (sh[1] != 0 || m_tick == 2 * sh[0] + 1);
    endfunction

    // reference model, advanced on the same edge the design uses
    always @(posedge clk) begin
        if (rst) begin
            m_run <= 1'b0; m_tick <= 0; m_x <= 0; m_y <= 0;
            for (int i = 0; i < NCFG; i++) sh[i] <= 0;
        end else if (!m_run) begin
            m_tick <= 0; m_x <= 0; m_y <= 0;
            if (pwr_en) begin
                m_run <= 1'b1;
                for (int i = 0; i < NCFG; i++) sh[i] <= live[i];
            end
        end else if (exp_ce()) begin
            m_tick <= 0;
            if (m_x == h_total() - 1) begin
                m_x <= 0;
                if (m_y == v_total() - 1) begin
                    m_y <= 0;
                    if (pwr_en) begin
                        for (int i = 0; i < NCFG; i++) sh[i] <= live[i];
                    end else begin
                        m_run <= 1'b0;
                    end
                end else begin
                    m_y <= m_y + 1;
                end
            end else begin
                m_x <= m_x + 1;
            end
        end else begin
            m_tick <= m_tick + 1;
        end
    end

    task automatic chk(input string tag, input string name, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, name, act, exp, $time);
        end
    endtask

    function automatic string pick(input string base);
        bit differs = 1'b0;
        for (int i = 0; i < NCFG; i++) if (live[i] != sh[i]) differs = 1'b1;
        if (rst_phase) return "R11";
        if (m_run && differs) return "R9";
        return base;
    endfunction

    task automatic check_all();
        bit hs, vs, d;
        hs = m_run && m_x >= hs_first() && m_x < hs_first() + sh[4] + 1;
        vs = m_run && m_y >= vs_first() && m_y < vs_first() + sh[8] + 1;
        d  = m_run && m_x <= sh[2] && m_y <= sh[6];
        chk(pick(sh[1] != 0 ? "R2" : "R1"), "pix_ce", int'(pix_ce), int'(exp_ce()));
        chk(pick("R3"), "pix_x", int'(pix_x), m_x);
        chk(pick("R4"), "line_y", int'(line_y), m_y);
        chk(pick(sh[10] != 0 ? "R7" : "R5"), "hsync", int'(hsync), int'(hs ^ sh[10][0]));
        chk(pick(sh[11] != 0 ? "R7" : "R6"), "vsync", int'(vsync), int'(vs ^ sh[11][0]));
        chk(pick("R8"), "de", int'(de), int'(d));
        chk(pick("R10"), "busy", int'(busy), int'(m_run));
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_all();
        end
    endtask

    task automatic set_cfg(input int dv, input int by, input int ha, input int hf,
                           input int hs, input int hb, input int va, input int vf,
                           input int vs, input int vb, input int hi, input int vi);
        live[0] = dv; live[1] = by; live[2] = ha; live[3] = hf;
        live[4] = hs; live[5] = hb; live[6] = va; live[7] = vf;
        live[8] = vs; live[9] = vb; live[10] = hi; live[11] = vi;
    endtask

    initial begin
        int seed;
        seed = 32'h1D5C;
        void'($urandom(seed));
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R11: idle state after reset
        run_cycles(3);
        rst_phase = 1'b0;

        // R2: bypass, every field at its minimum, zero vertical porches
        set_cfg(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        pwr_en = 1'b1;
        run_cycles(40);

        // R1, R7: divided strobe with inverted syncs
        @(negedge clk);
        set_cfg(1, 0, 3, 1, 0, 2, 2, 1, 1, 2, 1, 1);
        run_cycles(1200);

        // R9: change fields mid-frame
        set_cfg(2, 0, 5, 0, 2, 1, 3, 0, 0, 1, 0, 1);
        run_cycles(2500);

        // R10: power down mid-frame, finish frame, rest idle
        pwr_en = 1'b0;
        run_cycles(4000);
        pwr_en = 1'b1;
        run_cycles(300);

        for (int r = 0; r < 40; r++) begin
            set_cfg($urandom_range(0, 3), ($urandom_range(0, 3) == 0) ? 1 : 0,
                    $urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 3),
                    $urandom_range(0, 3), $urandom_range(0, 5), $urandom_range(0, 2),
                    $urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(0, 1),
                    $urandom_range(0, 1));
            pwr_en = ($urandom_range(0, 7) != 0);
            run_cycles($urandom_range(200, 1500));
        end
        pwr_en = 1'b0;
        run_cycles(3500);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule